// File: doc/BRIEF.md
# Multiplexed Decimal Display Scan Controller

This block scans a bank of sixteen decimal indicators that share one BCD cathode decoder. The sixteen four-bit digit codes live in a 64-bit recirculating shift register rather than in an addressable memory. The block runs on one clock and has two strobes. The host strobe paces the serial fill from an external memory. The scan strobe paces the display rotation.

An active-low write request starts a fill. Each host strobe then shifts one serial bit into the top of the register, and the block counts the bits. The 64th bit ends the fill and drives the active-low display flag low. From then on, each scan strobe rotates the register by one position. The bit that leaves the low end re-enters at the top, so the codes are never lost.

A four-step phase counter marks when a whole word sits in the four lowest bits. On those steps the block pulls low the anode select for the current digit and presents the code on the BCD outputs. During the other three steps the anodes stay blanked while the next word moves into place. A write request at any time stops the scan and starts a fresh fill. After that fill, the scan starts again from digit 0.

Top module: `disp_scan_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters idle: `disp_n` high, all `anode_n` bits high, all counters cleared. Scan strobes in idle change nothing at the outputs.
- R2: A low `wr_req_n` at a clock edge starts a fill. During the fill, each edge with `host_tick` high shifts `mem_bit` into the register. Edges without `host_tick` neither shift nor count.
- R3: The edge that takes the 64th fill bit drives `disp_n` low. After that, `host_tick` and `mem_bit` have no effect on what is displayed.
- R4: During idle and during a fill, every `anode_n` bit stays high.
- R5: In display, each scan strobe rotates the register by one bit, with the low bit fed back to the top. A digit shows the same code again 64 strobes later.
- R6: In display, exactly one `anode_n` bit is low, but only while the number of scan strobes since display entry is a multiple of four. For the three strobes in between, all anodes are blanked.
- R7: Digit position k is the k-th loaded group of four bits, taken least significant bit first. While digit k is selected, `anode_n[k]` is low and `bcd` carries that word.
- R8: The digit position advances once every four scan strobes and wraps from 15 to 0.
- R9: A write request during display drives `disp_n` high and blanks all anodes at the next edge, even if a scan strobe arrives in the same cycle. A complete new fill follows, and display then resumes at digit 0.
- R10: In display, cycles without a scan strobe leave `anode_n` and `bcd` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_req_n | input | 1 | Fill request, active low |
| host_tick | input | 1 | Host strobe, one fill bit per high cycle |
| mem_bit | input | 1 | Serial data from external memory |
| scan_tick | input | 1 | Scan strobe, one rotation per high cycle |
| disp_n | output | 1 | Display flag, low while scanning |
| anode_n | output | 16 | One-of-16 anode select, active low |
| bcd | output | 4 | BCD code of the selected digit |

## Verification
The hardest situation to reach is a write request that lands in the middle of a scan, with a scan strobe in the same cycle. Reaching it needs a complete fill first and then a scan stopped partway through a digit interval. The bench fills the register with a ragged host strobe, scans for 22 strobes, and then raises both the request and the strobe together. It then refills with a second pattern and checks that scanning restarts at digit 0 with the new codes. Scan and host strobes are also driven in the phases where they must be ignored.

// File: rtl/disp_scan_pkg.sv
// Package: shared parameters and the phase type of the display scan controller.
// Assumes: every module of the block imports this package.
package disp_scan_pkg;

    // Default digit count and word width.
    localparam int unsigned DEF_DIGITS = 16;
    localparam int unsigned DEF_WORD_W = 4;
    localparam int unsigned DEF_GROUP  = 8;

    // Operating phase of the controller.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_SHOW = 2'd2
    } scan_phase_e;

endpackage

// File: rtl/scan_sequencer.sv
// Module: scan_sequencer
// Does: runs the idle/fill/show phases, counts fill bits, counts the shift step
// inside a word, and counts the digit position.
// Assumes: WORD_W is a power of two of at least 2, and strobes last one cycle each.
module scan_sequencer
    import disp_scan_pkg::*;
#(
    parameter int unsigned DIGITS = DEF_DIGITS,
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_req_n,
    input  logic                        host_tick,
    input  logic                        scan_tick,
    output logic                        shift_en,
    output logic                        take_ext,
    output logic                        showing,
    output logic                        aligned,
    output logic [$clog2(DIGITS)-1:0]   digit
);
    localparam int unsigned TOTAL_BITS = DIGITS * WORD_W;
    localparam int unsigned CNT_W      = $clog2(TOTAL_BITS);
    localparam int unsigned STEP_W     = $clog2(WORD_W);
    localparam int unsigned DIG_W      = $clog2(DIGITS);
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(TOTAL_BITS - 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(WORD_W - 1);
    localparam logic [DIG_W-1:0]  LAST_DIG  = DIG_W'(DIGITS - 1);

    scan_phase_e        phase_q;
    logic [CNT_W-1:0]   bit_cnt_q;
    logic [STEP_W-1:0]  step_q;
    logic [DIG_W-1:0]   digit_q;
    logic               fill_shift;
    logic               show_shift;

    // Fill shifts take external data; show shifts recirculate; a request overrides both.
    always_comb begin
        fill_shift = wr_req_n && (phase_q == PH_FILL) && host_tick;
        show_shift = wr_req_n && (phase_q == PH_SHOW) && scan_tick;
    end

    // Phase, bit counter, step counter and digit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            bit_cnt_q <= '0;
            step_q    <= '0;
            digit_q   <= '0;
        end else if (!wr_req_n) begin
            phase_q   <= PH_FILL;
            bit_cnt_q <= '0;
            step_q    <= '0;
            digit_q   <= '0;
        end else if (fill_shift) begin
            if (bit_cnt_q == LAST_BIT) begin
                phase_q   <= PH_SHOW;
                bit_cnt_q <= '0;
            end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
        end else if (show_shift) begin
            step_q <= step_q + 1'b1;
            if (step_q == LAST_STEP) begin
                digit_q <= (digit_q == LAST_DIG) ? '0 : digit_q + 1'b1;
            end
        end
    end

    // Outputs seen by the store and the decoder.
    always_comb begin
        shift_en = fill_shift || show_shift;
        take_ext = fill_shift;
        showing  = (phase_q == PH_SHOW);
        aligned  = (phase_q == PH_SHOW) && (step_q == '0);
        digit    = digit_q;
    end

endmodule

// File: rtl/digit_store.sv
// Module: digit_store
// Does: holds all digit codes in one right-shifting register; the top bit takes
// either the serial input or the bit that leaves the low end.
// Assumes: the low WORD_W bits hold the word that is currently aligned.
module digit_store #(
    parameter int unsigned TOTAL_BITS = 64,
    parameter int unsigned WORD_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              take_ext,
    input  logic              ext_bit,
    output logic [WORD_W-1:0] word
);
    logic [TOTAL_BITS-1:0] sreg_q;
    logic                  top_bit;

    // Pick the bit that enters at the top.
    always_comb top_bit = take_ext ? ext_bit : sreg_q[0];

    // Shift one position toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (shift_en) begin
            sreg_q <= {top_bit, sreg_q[TOTAL_BITS-1:1]};
        end
    end

    // Aligned word at the low end.
    always_comb word = sreg_q[WORD_W-1:0];

endmodule

// File: rtl/group_decoder.sv
// Module: group_decoder
// Does: one-of-GROUP decoder with an enable and active-low outputs.
// Assumes: GROUP is a power of two of at least 2.
module group_decoder #(
    parameter int unsigned GROUP = 8
) (
    input  logic                       en,
    input  logic [$clog2(GROUP)-1:0]   sel,
    output logic [GROUP-1:0]           y_n
);
    localparam int unsigned SEL_W = $clog2(GROUP);

    for (genvar i = 0; i < GROUP; i++) begin : g_out
        // Drive output i low only when it is enabled and selected.
        always_comb y_n[i] = !(en && (sel == SEL_W'(i)));
    end

endmodule

// File: rtl/anode_decoder.sv
// Module: anode_decoder
// Does: builds the active-low one-of-DIGITS anode select from group decoders.
// The high digit bits enable one group, and the low bits select within it.
// Assumes: DIGITS is a power-of-two multiple of GROUP.
module anode_decoder #(
    parameter int unsigned DIGITS = 16,
    parameter int unsigned GROUP  = 8
) (
    input  logic                        en,
    input  logic [$clog2(DIGITS)-1:0]   digit,
    output logic [DIGITS-1:0]           anode_n
);
    localparam int unsigned DIG_W  = $clog2(DIGITS);
    localparam int unsigned SEL_W  = $clog2(GROUP);
    localparam int unsigned GROUPS = DIGITS / GROUP;

    if (GROUPS == 1) begin : g_single
        group_decoder #(.GROUP(GROUP)) u_grp (
            .en  (en),
            .sel (digit[SEL_W-1:0]),
            .y_n (anode_n)
        );
    end else begin : g_multi
        localparam int unsigned HI_W = DIG_W - SEL_W;
        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            logic grp_en;
            // Enable this group when the high digit bits match its index.
            always_comb grp_en = en && (digit[DIG_W-1:SEL_W] == HI_W'(g));
            group_decoder #(.GROUP(GROUP)) u_grp (
                .en  (grp_en),
                .sel (digit[SEL_W-1:0]),
                .y_n (anode_n[g*GROUP +: GROUP])
            );
        end
    end

endmodule

// File: rtl/disp_scan_ctrl.sv
// Module: disp_scan_ctrl (top)
// Does: fills a recirculating digit register from a serial memory and then
// multiplexes the digits, one anode at a time, with blanking between words.
// Assumes: one clock; host_tick and scan_tick are clock-enable strobes.
module disp_scan_ctrl
    import disp_scan_pkg::*;
#(
    parameter int unsigned DIGITS = DEF_DIGITS,
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned GROUP  = DEF_GROUP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req_n,
    input  logic              host_tick,
    input  logic              mem_bit,
    input  logic              scan_tick,
    output logic              disp_n,
    output logic [DIGITS-1:0] anode_n,
    output logic [WORD_W-1:0] bcd
);
    localparam int unsigned TOTAL_BITS = DIGITS * WORD_W;
    localparam int unsigned DIG_W      = $clog2(DIGITS);

    logic             shift_en;
    logic             take_ext;
    logic             showing;
    logic             aligned;
    logic [DIG_W-1:0] digit;

    scan_sequencer #(.DIGITS(DIGITS), .WORD_W(WORD_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req_n  (wr_req_n),
        .host_tick (host_tick),
        .scan_tick (scan_tick),
        .shift_en  (shift_en),
        .take_ext  (take_ext),
        .showing   (showing),
        .aligned   (aligned),
        .digit     (digit)
    );

    digit_store #(.TOTAL_BITS(TOTAL_BITS), .WORD_W(WORD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .take_ext (take_ext),
        .ext_bit  (mem_bit),
        .word     (bcd)
    );

    anode_decoder #(.DIGITS(DIGITS), .GROUP(GROUP)) u_dec (
        .en      (aligned),
        .digit   (digit),
        .anode_n (anode_n)
    );

    // Display flag, low while scanning.
    always_comb disp_n = !showing;

endmodule

// File: rtl/disp_scan_ctrl_chk.sv
// Module: disp_scan_ctrl_chk
// Does: holds the temporal checks on the top-level ports; attached by bind.
// Assumes: the same parameters as the top module.
module disp_scan_ctrl_chk #(
    parameter int unsigned DIGITS = 16,
    parameter int unsigned WORD_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_req_n,
    input logic              host_tick,
    input logic              scan_tick,
    input logic              disp_n,
    input logic [DIGITS-1:0] anode_n,
    input logic [WORD_W-1:0] bcd
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (disp_n && (&anode_n)));

    assert_fill_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        disp_n |-> (&anode_n));

    assert_fill_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disp_n) |-> $past(host_tick));

    assert_single_anode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~anode_n) <= 1);

    assert_blank_after_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((!(&anode_n)) && scan_tick && wr_req_n) |=> (&anode_n));

    assert_request_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req_n |=> (disp_n && (&anode_n)));

    assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_n && !scan_tick && wr_req_n) |=> ($stable(anode_n) && $stable(bcd)));

endmodule

bind disp_scan_ctrl disp_scan_ctrl_chk #(.DIGITS(DIGITS), .WORD_W(WORD_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req_n  (wr_req_n),
    .host_tick (host_tick),
    .scan_tick (scan_tick),
    .disp_n    (disp_n),
    .anode_n   (anode_n),
    .bcd       (bcd)
);

// File: tb/disp_scan_ctrl_tb_top.sv
module disp_scan_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req_n = 1'b1;
    logic        host_tick = 1'b0;
    logic        mem_bit = 1'b0;
    logic        scan_tick = 1'b0;
    logic        disp_n;
    logic [15:0] anode_n;
    logic [3:0]  bcd;

    int errors = 0;
    int checks = 0;
    logic [3:0] exp_w [16];

    always #2 clk = ~clk;

    disp_scan_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_req_n(wr_req_n), .host_tick(host_tick),
        .mem_bit(mem_bit), .scan_tick(scan_tick), .disp_n(disp_n),
        .anode_n(anode_n), .bcd(bcd)
    );

    // One clock edge; inputs were set at a falling edge, outputs sampled at the next.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_anode(input int t);
        if (t % 4 == 0) return ~(16'h1 << ((t / 4) % 16));
        return 16'hFFFF;
    endfunction

    task automatic set_pattern(input int seed);
        for (int i = 0; i < 16; i++) exp_w[i] = 4'((seed + i * 7) % 10);
    endtask

    // Fill with the current pattern; optional gap cycles carry scan strobes and junk bits.
    task automatic do_fill(input bit gaps);
        wr_req_n = 1'b0;
        step();
        wr_req_n = 1'b1;
        chk("R9 flag high after request", disp_n, 1);
        chk("R4 blank after request", anode_n, 16'hFFFF);
        for (int i = 0; i < 64; i++) begin
            if (gaps && (i % 7 == 3)) begin
                host_tick = 1'b0; scan_tick = 1'b1; mem_bit = 1'b1;
                step();
                chk("R2 gap not counted", disp_n, 1);
                chk("R4 blank in fill gap", anode_n, 16'hFFFF);
            end
            host_tick = 1'b1; scan_tick = 1'b0;
            mem_bit = exp_w[i / 4][i % 4];
            step();
            if (i < 63) begin
                chk("R3 flag high before last bit", disp_n, 1);
                chk("R4 blank during fill", anode_n, 16'hFFFF);
            end else begin
                chk("R3 flag low after last bit", disp_n, 0);
            end
        end
        host_tick = 1'b0;
    endtask

    // Scan n strobes from display entry, with idle cycles carrying host junk.
    task automatic do_scan(input int n);
        chk("R7 first digit select", anode_n, exp_anode(0));
        chk("R7 first digit code", bcd, exp_w[0]);
        for (int t = 1; t <= n; t++) begin
            scan_tick = 1'b1;
            step();
            scan_tick = 1'b0;
            chk("R6 R8 anode select", anode_n, exp_anode(t));
            if (t % 4 == 0) chk("R5 R7 code", bcd, exp_w[(t / 4) % 16]);
            if (t % 5 == 0) begin
                host_tick = 1'b1; mem_bit = ~mem_bit;
                step();
                host_tick = 1'b0;
                chk("R10 R3 hold without strobe", anode_n, exp_anode(t));
                if (t % 4 == 0) chk("R10 code hold", bcd, exp_w[(t / 4) % 16]);
            end
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        chk("R1 flag after reset", disp_n, 1);
        chk("R1 anodes after reset", anode_n, 16'hFFFF);
        scan_tick = 1'b1;
        for (int i = 0; i < 8; i++) begin
            step();
            chk("R1 idle ignores scan", anode_n, 16'hFFFF);
        end
        scan_tick = 1'b0;
        chk("R1 idle flag", disp_n, 1);
    endtask

    task automatic test_fill_scan();
        set_pattern(3);
        do_fill(1'b1);
        do_scan(140);
    endtask

    task automatic test_reload();
        set_pattern(5);
        do_fill(1'b0);
        do_scan(22);
        wr_req_n = 1'b0; scan_tick = 1'b1;
        step();
        wr_req_n = 1'b1; scan_tick = 1'b0;
        chk("R9 flag high on request", disp_n, 1);
        chk("R9 blank on request", anode_n, 16'hFFFF);
        set_pattern(8);
        for (int i = 0; i < 64; i++) begin
            host_tick = 1'b1; mem_bit = exp_w[i / 4][i % 4];
            step();
        end
        host_tick = 1'b0;
        chk("R9 display after refill", disp_n, 0);
        chk("R9 restart at digit 0", anode_n, 16'hFFFE);
        chk("R9 new code", bcd, exp_w[0]);
        do_scan(70);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_fill_scan();
        test_reload();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule